// File: doc/BRIEF.md
# Mask-Gated Serial Sparse Neuron

This block computes one output of a sparsely-connected fully-connected layer, taking one input activation per clock. An on-chip linear-feedback shift register, compared against a fixed threshold, produces a connection bit for every input position. Only inputs whose connection bit is set use a weight. The weight memory therefore holds just the weights of the kept connections, packed in input order. A weight address counter moves forward only on kept inputs, so a short weight memory is walked in step with a full-length input stream. A full vector of N inputs still takes N accepted cycles, the same as a dense neuron.

A start pulse reseeds the mask generator, zeroes the weight address and opens a new vector. The input offered in the same cycle as the start, if any, is the vector's first element. The weight memory sits outside the block and is read synchronously. The block therefore issues the address and read enable in the cycle the input is accepted, and performs the multiply-accumulate one cycle later, when the weight arrives. The sum saturates at the accumulator limits. After the N-th input, the sum goes through a rectifier (negative values become zero) and is presented with a one-cycle valid pulse. A parameter selects a variant in which the multiplier is replaced by a sign selector that adds +x or −x depending on the stored weight.

Top module: `mask_gated_neuron`

## Requirements
- R1: A vector is opened by `in_start` and consists of exactly N_INPUTS (default 16) accepted inputs. An input is accepted when `in_valid` is high and a vector is open, or when `in_start` is high in the same cycle. `in_valid` while no vector is open is ignored: it causes no read and no output.
- R2: The connection bit comes from a 4-bit shift register with default seed 9. Each accepted input advances it to {s[2:0], s[3]^s[2]}. A start reloads the seed, so the first input of a vector sees the seed. The connection bit is 1 when the current value is 6 or more.
- R3: For an accepted input with connection bit 1, `wgt_rd_en` is high in that cycle and `wgt_addr` equals the number of connected inputs earlier in the same vector. The product of that input and the returned weight is added to the sum.
- R4: For an accepted input with connection bit 0, `wgt_rd_en` stays low, `wgt_addr` keeps its value and the sum is not changed.
- R5: The weight memory answers one cycle after `wgt_rd_en`, and that weight is paired with the input accepted in the cycle of the read.
- R6: The running sum is signed, ACC_W bits wide (default 16), and saturates at +32767 and −32768 at every step instead of wrapping.
- R7: The output is the final sum when it is positive, and zero otherwise.
- R8: `out_valid` is a single-cycle pulse that appears two clock edges after the edge that accepts the N-th input. `out_data` holds its value between pulses.
- R9: With MODE set to sign-select, the weight is not multiplied. A weight ≥ 0 (as a signed value) adds +x and a negative weight adds −x.
- R10: A start during an open vector abandons it without an output. A start in the cycle right after a vector's last input opens the next vector while the previous vector still completes and emits its result.
- R11: After reset, `out_valid` and `wgt_rd_en` are low, `out_data` is zero and no vector is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_start | input | 1 | Opens a new vector and reseeds the mask generator |
| in_valid | input | 1 | Input activation is present |
| in_data | input | DATA_W | Signed input activation |
| wgt_rd_en | output | 1 | Read strobe to the compressed weight memory |
| wgt_addr | output | ADDR_W | Address of the next stored weight |
| wgt_rdata | input | WGT_W | Signed weight returned one cycle after the read |
| out_valid | output | 1 | One-cycle pulse marking a finished neuron output |
| out_data | output | ACC_W | Rectified, saturated sum |

## Verification
The start of a new vector and the final multiply-accumulate of the previous vector can fall in the same cycle. In that cycle the front stage clears the address and reseeds the generator, while the back stage is still adding the last product into the old sum. The bench provokes this by issuing `in_start` with the new vector's first input in the cycle right after the previous vector's last input. It judges the result by requiring both expected outputs, each at its computed cycle and value, with no extra pulse. A start part-way through a vector, overlapping an in-flight product, is also provoked and must yield only the fresh vector's result.

// File: rtl/mgn_pkg.sv
package mgn_pkg;

    typedef enum logic {
        MAC_MULTIPLY    = 1'b0,
        MAC_SIGN_SELECT = 1'b1
    } mac_mode_e;

    // control word travelling from the address stage to the accumulate stage
    typedef struct packed {
        logic valid;
        logic keep;
        logic first;
        logic last;
    } stage_ctl_t;

    // maximal-length feedback tap sets for a left-shifting register
    function automatic logic [31:0] lfsr_taps(input int width);
        case (width)
            3:       return 32'h0000_0006;
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            11:      return 32'h0000_0500;
            12:      return 32'h0000_0E08;
            13:      return 32'h0000_1C80;
            14:      return 32'h0000_3802;
            15:      return 32'h0000_6000;
            default: return 32'h0000_B400;
        endcase
    endfunction

endpackage

// File: rtl/mgn_mask_gen.sv
module mgn_mask_gen #(
    parameter int LFSR_W = 4,
    parameter int SEED   = 9,
    parameter int THRESH = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic reseed,
    input  logic advance,
    output logic keep
);
    import mgn_pkg::*;

    localparam logic [LFSR_W-1:0] TAPS     = LFSR_W'(lfsr_taps(LFSR_W));
    localparam logic [LFSR_W-1:0] SEED_V   = LFSR_W'(SEED);
    localparam logic [LFSR_W-1:0] THRESH_V = LFSR_W'(THRESH);

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] cur;
    logic [LFSR_W-1:0] nxt;
    logic              fb;

    always_comb begin
        cur  = reseed ? SEED_V : state_q;
        fb   = ^(cur & TAPS);
        nxt  = {cur[LFSR_W-2:0], fb};
        keep = (cur >= THRESH_V);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED_V;
        end else if (advance) begin
            state_q <= nxt;
        end else if (reseed) begin
            state_q <= SEED_V;
        end
    end

endmodule

// File: rtl/mgn_seq.sv
module mgn_seq #(
    parameter int N_INPUTS = 16,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_start,
    input  logic              in_valid,
    input  logic              keep,
    output logic              accept,
    output logic              is_first,
    output logic              is_last,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int CNT_W = (N_INPUTS > 1) ? $clog2(N_INPUTS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_INPUTS - 1);

    logic              open_q;
    logic              first_pend_q;
    logic [CNT_W-1:0]  in_cnt_q;
    logic [ADDR_W-1:0] addr_q;

    logic [CNT_W-1:0]  cnt_eff;
    logic [ADDR_W-1:0] addr_eff;

    always_comb begin
        cnt_eff  = in_start ? '0 : in_cnt_q;
        addr_eff = in_start ? '0 : addr_q;
        accept   = in_valid & (in_start | open_q);
        is_first = in_start | first_pend_q;
        is_last  = (cnt_eff == LAST_IDX);
        rd_en    = accept & keep;
        rd_addr  = addr_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q       <= 1'b0;
            first_pend_q <= 1'b0;
            in_cnt_q     <= '0;
            addr_q       <= '0;
        end else begin
            if (in_start) begin
                open_q       <= 1'b1;
                first_pend_q <= 1'b1;
                in_cnt_q     <= '0;
                addr_q       <= '0;
            end
            if (accept) begin
                first_pend_q <= 1'b0;
                addr_q       <= addr_eff + ADDR_W'(keep);
                if (is_last) begin
                    open_q   <= 1'b0;
                    in_cnt_q <= '0;
                end else begin
                    in_cnt_q <= cnt_eff + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mgn_mac.sv
module mgn_mac
    import mgn_pkg::*;
#(
    parameter int        DATA_W = 8,
    parameter int        WGT_W  = 8,
    parameter int        ACC_W  = 16,
    parameter mac_mode_e MODE   = MAC_MULTIPLY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_accept,
    input  logic              in_keep,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    input  logic [WGT_W-1:0]  wgt_rdata,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);
    localparam int PROD_W = DATA_W + WGT_W;
    localparam int EXT_W  = ACC_W + 1 - PROD_W;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    stage_ctl_t                ctl_q;
    logic signed [DATA_W-1:0]  x_q;
    logic signed [ACC_W-1:0]   acc_q;

    logic signed [WGT_W-1:0]   w_s;
    logic signed [PROD_W-1:0]  prod;
    logic signed [ACC_W-1:0]   base;
    logic signed [ACC_W:0]     sum;
    logic signed [ACC_W-1:0]   sum_sat;
    logic signed [ACC_W-1:0]   acc_nxt;
    logic        [ACC_W-1:0]   rect;

    assign w_s = $signed(wgt_rdata);

    generate
        if (MODE == MAC_SIGN_SELECT) begin : g_sign_sel
            logic signed [PROD_W-1:0] x_ext;
            assign x_ext = {{WGT_W{x_q[DATA_W-1]}}, x_q};
            assign prod  = (w_s >= 0) ? x_ext : -x_ext;
        end else begin : g_mult
            assign prod = x_q * w_s;
        end
    endgenerate

    always_comb begin
        base = ctl_q.first ? '0 : acc_q;
        sum  = {base[ACC_W-1], base} + {{EXT_W{prod[PROD_W-1]}}, prod};
        if (sum[ACC_W] != sum[ACC_W-1]) begin
            sum_sat = sum[ACC_W] ? ACC_MIN : ACC_MAX;
        end else begin
            sum_sat = sum[ACC_W-1:0];
        end
        acc_nxt = ctl_q.keep ? sum_sat : base;
        rect    = acc_nxt[ACC_W-1] ? '0 : acc_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            x_q       <= '0;
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            ctl_q     <= '{valid: in_accept, keep: in_keep & in_accept,
                           first: in_first,  last: in_last & in_accept};
            x_q       <= $signed(in_data);
            out_valid <= ctl_q.valid & ctl_q.last;
            if (ctl_q.valid) begin
                acc_q <= acc_nxt;
            end
            if (ctl_q.valid & ctl_q.last) begin
                out_data <= rect;
            end
        end
    end

endmodule

// File: rtl/mask_gated_neuron.sv
module mask_gated_neuron
    import mgn_pkg::*;
#(
    parameter int        N_INPUTS    = 16,
    parameter int        DATA_W      = 8,
    parameter int        WGT_W       = 8,
    parameter int        ACC_W       = 16,
    parameter int        WMEM_DEPTH  = 12,
    parameter int        LFSR_W      = 4,
    parameter int        SEED        = 9,
    parameter int        MASK_THRESH = 6,
    parameter mac_mode_e MODE        = MAC_MULTIPLY,
    localparam int       ADDR_W      = (WMEM_DEPTH > 1) ? $clog2(WMEM_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_start,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              wgt_rd_en,
    output logic [ADDR_W-1:0] wgt_addr,
    input  logic [WGT_W-1:0]  wgt_rdata,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);

    logic keep;
    logic accept;
    logic is_first;
    logic is_last;

    mgn_mask_gen #(
        .LFSR_W (LFSR_W),
        .SEED   (SEED),
        .THRESH (MASK_THRESH)
    ) u_mask (
        .clk     (clk),
        .rst     (rst),
        .reseed  (in_start),
        .advance (accept),
        .keep    (keep)
    );

    mgn_seq #(
        .N_INPUTS (N_INPUTS),
        .ADDR_W   (ADDR_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_start (in_start),
        .in_valid (in_valid),
        .keep     (keep),
        .accept   (accept),
        .is_first (is_first),
        .is_last  (is_last),
        .rd_en    (wgt_rd_en),
        .rd_addr  (wgt_addr)
    );

    mgn_mac #(
        .DATA_W (DATA_W),
        .WGT_W  (WGT_W),
        .ACC_W  (ACC_W),
        .MODE   (MODE)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .in_accept (accept),
        .in_keep   (keep),
        .in_first  (is_first),
        .in_last   (is_last),
        .in_data   (in_data),
        .wgt_rdata (wgt_rdata),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/mgn_checker.sv
module mgn_checker #(
    parameter int ADDR_W     = 4,
    parameter int WMEM_DEPTH = 12,
    parameter int ACC_W      = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_start,
    input logic              in_valid,
    input logic              wgt_rd_en,
    input logic [ADDR_W-1:0] wgt_addr,
    input logic              out_valid,
    input logic [ACC_W-1:0]  out_data
);

    // R1: a weight read only happens for an offered input
    a_r1_read_needs_input: assert property (@(posedge clk) disable iff (rst)
        wgt_rd_en |-> in_valid);

    // R3: a connected input moves the address forward by one
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (wgt_rd_en ##1 !in_start) |-> (wgt_addr == ADDR_W'($past(wgt_addr) + 1'b1)));

    // R3: reads stay inside the compressed memory
    a_r3_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        wgt_rd_en |-> ({1'b0, wgt_addr} < (ADDR_W+1)'(WMEM_DEPTH)));

    // R4: an unconnected or idle cycle leaves the address alone
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!wgt_rd_en ##1 !in_start) |-> $stable(wgt_addr));

    // R7: a presented result is never negative
    a_r7_rectified: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_data[ACC_W-1]);

    // R8: the valid strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8: a result follows an input offered two edges earlier
    a_r8_after_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R11: the edge after reset shows no output strobe
    a_r11_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

bind mask_gated_neuron mgn_checker #(
    .ADDR_W     (ADDR_W),
    .WMEM_DEPTH (WMEM_DEPTH),
    .ACC_W      (ACC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_start  (in_start),
    .in_valid  (in_valid),
    .wgt_rd_en (wgt_rd_en),
    .wgt_addr  (wgt_addr),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/mask_gated_neuron_tb_top.sv
module mask_gated_neuron_tb_top;
    import mgn_pkg::*;

    localparam int N      = 16;
    localparam int DEPTH  = 12;
    localparam int NVEC   = 5;

    // table: input base, input step, weight base, weight step
    localparam int TV [NVEC][4] = '{
        '{   1,  1,   1,  1},
        '{ 127,  0, 127,  0},
        '{-128, 16, 127,  0},
        '{  10, -3,  -5,  2},
        '{  -7,  5,   3, -9}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_start = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             rd_en_i, rd_en_b;
    logic [3:0]       addr_i, addr_b;
    logic [7:0]       rdata_i = '0;
    logic [7:0]       rdata_b = '0;
    logic             ov_i, ov_b;
    logic [15:0]      od_i, od_b;

    logic signed [7:0] wmem [DEPTH];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    int exp_mul_q[$];
    int exp_bin_q[$];
    int exp_cyc_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    mask_gated_neuron dut_i (
        .clk(clk), .rst(rst), .in_start(in_start), .in_valid(in_valid),
        .in_data(in_data), .wgt_rd_en(rd_en_i), .wgt_addr(addr_i),
        .wgt_rdata(rdata_i), .out_valid(ov_i), .out_data(od_i));

    mask_gated_neuron #(.MODE(MAC_SIGN_SELECT)) dut_b (
        .clk(clk), .rst(rst), .in_start(in_start), .in_valid(in_valid),
        .in_data(in_data), .wgt_rd_en(rd_en_b), .wgt_addr(addr_b),
        .wgt_rdata(rdata_b), .out_valid(ov_b), .out_data(od_b));

    // synchronous weight memories
    always @(posedge clk) begin
        if (rd_en_i) rdata_i <= wmem[addr_i];
        if (rd_en_b) rdata_b <= wmem[addr_b];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic logic [3:0] lfsr_next(input logic [3:0] s);
        return {s[2:0], s[3] ^ s[2]};
    endfunction

    // output monitor: every pulse must match the next expectation
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (ov_i) begin
                if (exp_mul_q.size() == 0) begin
                    chk(0, "R8/R10 unexpected out_valid", 1, 0);
                end else begin
                    int em, eb, ec;
                    em = exp_mul_q.pop_front();
                    eb = exp_bin_q.pop_front();
                    ec = exp_cyc_q.pop_front();
                    chk(cyc == ec, "R8 output cycle", cyc, ec);
                    chk(int'(od_i) == em, "R3/R5/R6/R7 result", int'(od_i), em);
                    chk(ov_b == 1'b1, "R9 sign-select valid", int'(ov_b), 1);
                    chk(int'(od_b) == eb, "R9 sign-select result", int'(od_b), eb);
                end
            end else if (ov_b) begin
                chk(0, "R9 stray sign-select valid", 1, 0);
            end
        end
    end

    task automatic load_weights(input int wb, input int ws);
        for (int k = 0; k < DEPTH; k++) wmem[k] = 8'(wb + ws * k);
    endtask

    // drives one vector; with_first puts the first input in the start cycle
    task automatic run_vec(input int xb, input int xs, input bit with_first);
        logic signed [7:0] xv [N];
        bit                mk [N];
        int                kk [N];
        logic [3:0]        s;
        int                k, am, ab, xi, wk;
        s = 4'd9; k = 0; am = 0; ab = 0;
        for (int i = 0; i < N; i++) begin
            xv[i] = 8'(xb + xs * i);
            mk[i] = (s >= 4'd6);
            kk[i] = k;
            if (mk[i]) begin
                xi = int'(xv[i]);
                wk = int'(wmem[k]);
                am = sat16(am + xi * wk);
                ab = sat16(ab + ((wk >= 0) ? xi : -xi));
                k++;
            end
            s = lfsr_next(s);
        end
        if (!with_first) begin
            in_start = 1'b1; in_valid = 1'b0;
            @(negedge clk);
        end
        for (int i = 0; i < N; i++) begin
            in_start = (i == 0) && with_first;
            in_valid = 1'b1;
            in_data  = xv[i];
            #1;
            chk(rd_en_i == mk[i], "R2/R3/R4 read enable", int'(rd_en_i), int'(mk[i]));
            if (mk[i]) chk(int'(addr_i) == kk[i], "R3 weight address", int'(addr_i), kk[i]);
            if (i == N - 1) begin
                exp_mul_q.push_back(am > 0 ? am : 0);
                exp_bin_q.push_back(ab > 0 ? ab : 0);
                exp_cyc_q.push_back(cyc + 2);
            end
            @(negedge clk);
        end
        in_start = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_start = 1'b0; in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        load_weights(1, 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state, and R1: input with no open vector is ignored
        in_valid = 1'b1; in_data = 8'd50;
        #1;
        chk(ov_i == 1'b0, "R11 out_valid after reset", int'(ov_i), 0);
        chk(od_i == 16'd0, "R11 out_data after reset", int'(od_i), 0);
        chk(rd_en_i == 1'b0, "R11/R1 no read while closed", int'(rd_en_i), 0);
        idle(3);

        // table-driven vectors, opened by a separate start pulse
        for (int v = 0; v < NVEC; v++) begin
            load_weights(TV[v][2], TV[v][3]);
            run_vec(TV[v][0], TV[v][1], 1'b0);
            idle(3);
        end

        // R1: inputs after the last one, without start, are ignored
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_data = 8'(90 + i);
            #1;
            chk(rd_en_i == 1'b0, "R1 ignored input causes no read", int'(rd_en_i), 0);
            @(negedge clk);
        end
        idle(4);

        // R10: start in the cycle right after the previous last input
        load_weights(TV[3][2], TV[3][3]);
        run_vec(TV[3][0], TV[3][1], 1'b1);
        run_vec(TV[4][0], TV[4][1], 1'b1);
        run_vec(TV[0][0], TV[0][1], 1'b1);
        idle(4);

        // R10: abandon a vector part-way, restart at once
        load_weights(TV[2][2], TV[2][3]);
        in_start = 1'b1; in_valid = 1'b1; in_data = 8'd100;
        @(negedge clk);
        in_start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            in_data = 8'(100 - 7 * i);
            @(negedge clk);
        end
        run_vec(TV[2][0], TV[2][1], 1'b1);
        idle(4);

        // R6: positive saturation again with a start-with-first entry
        load_weights(TV[1][2], TV[1][3]);
        run_vec(TV[1][0], TV[1][1], 1'b1);
        idle(5);

        chk(exp_mul_q.size() == 0, "R8 all results delivered", exp_mul_q.size(), 0);
        chk(od_i == 16'd32767, "R6 saturated hold value", int'(od_i), 32767);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule